// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the slave has been addressed. It watches the bytes that a receive shifter delivers after a START condition and compares the byte marked as the first after START against a programmed 8-bit own-address register. The upper seven bits of that register hold the slave address and the low bit holds a direction bit. Two addressing formats are supported. In the 7-bit format the direction bit of the received byte plays no part, and an all-zero byte counts as a general call. In the 10-bit format the first byte must equal the whole register.

A free-data mode turns address handling off. In that mode every accepted byte simply requests an interrupt, and the match flags stay where they are. START and STOP detection, both supplied by the line monitor, clear both flags. Bit shifting and ACK driving are done elsewhere.

Received bytes enter through a valid/ready input. The block never applies back-pressure: `byte_ready` is high whenever reset is released, so a byte transfers in every cycle where `byte_valid` is high. The outputs are registered and change one clock after the transfer.

Top module: `slv_addr_match`

## Requirements
- R1: After reset, `addr_hit`, `gcall_hit` and `irq_pulse` are 0. While reset is released, `byte_ready` is 1.
- R2: In 7-bit format (`fmt_ten`=0) with `free_data`=0, an accepted first byte whose bits [7:1] equal `own_addr[7:1]` sets `addr_hit` to 1 on the next cycle, whatever value bit 0 has. A first byte that neither matches nor is 0x00 sets `addr_hit` to 0.
- R3: In 7-bit format with `free_data`=0, an accepted first byte equal to 0x00 sets both `addr_hit` and `gcall_hit` to 1 on the next cycle.
- R4: In 10-bit format (`fmt_ten`=1) with `free_data`=0, an accepted first byte sets `addr_hit` to 1 only if all 8 bits equal `own_addr`. In this format a 0x00 byte never sets `gcall_hit`.
- R5: A cycle with `start_seen` or `stop_seen` high clears `addr_hit` and `gcall_hit` on the next cycle. A byte accepted in that same cycle is dropped and raises no interrupt.
- R6: An accepted byte with `byte_first`=0 leaves `addr_hit` and `gcall_hit` unchanged.
- R7: Once set, `gcall_hit` stays set until a START, a STOP or reset, even if a later first byte fails to match. `addr_hit` always reflects the most recent first byte.
- R8: With `free_data`=1, the flags are not changed by any byte, and each accepted byte gives a one-cycle `irq_pulse` on the next cycle.
- R9: With `free_data`=0, `irq_pulse` is high for one cycle after an accepted first byte that sets `addr_hit`. It stays low after a first byte that does not match and after any byte that is not a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A received byte is presented |
| byte_ready | output | 1 | Block accepts a byte (high out of reset) |
| byte_data | input | 8 | Received byte |
| byte_first | input | 1 | Byte is the first one after START |
| fmt_ten | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| free_data | input | 1 | 1 = address handling off |
| start_seen | input | 1 | START condition detected this cycle |
| stop_seen | input | 1 | STOP condition detected this cycle |
| own_addr | input | 8 | Own address register, bits [7:1] address, bit 0 direction |
| addr_hit | output | 1 | Slave address matched (or general call) |
| gcall_hit | output | 1 | General call received (sticky) |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `byte_ready` is high, so that every cycle with `byte_valid` high counts as a transfer. They also assume that `own_addr`, `fmt_ten` and `free_data` are settled in the cycle a byte is accepted. The stimulus changes these control inputs only in a cycle driven just before the edge. It raises START and STOP now and then, and sometimes together with a byte, to exercise the rule that a byte arriving with them is dropped. Bytes are drawn so that own-address matches, near misses in the direction bit and 0x00 all occur often.

// File: rtl/slv_addr_match_pkg.sv
package slv_addr_match_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic hit;
    logic gcall;
  } verdict_t;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_CLEAR = 2'd1,
    EV_ADDR  = 2'd2,
    EV_FREE  = 2'd3
  } event_e;
endpackage

// File: rtl/am_compare.sv
module am_compare
  import slv_addr_match_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] own,
  input  logic         ten_bit,
  output verdict_t     verdict
);
  localparam int unsigned AW = W - 1;

  logic [W-1:0] diff;
  logic         addr_eq7;
  logic         full_eq;
  logic         all_zero;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign diff[gi] = rx_byte[gi] ^ own[gi];
    end
  endgenerate

  always_comb begin
    addr_eq7 = (diff[W-1:W-AW] == '0);
    full_eq  = (diff == '0);
    all_zero = (rx_byte == '0);
    if (ten_bit) begin
      verdict.hit   = full_eq;
      verdict.gcall = 1'b0;
    end else begin
      verdict.hit   = addr_eq7 | all_zero;
      verdict.gcall = all_zero;
    end
  end
endmodule

// File: rtl/am_flags.sv
module am_flags
  import slv_addr_match_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  event_e   ev,
  input  verdict_t verdict,
  output logic     hit_q,
  output logic     gcall_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      gcall_q <= 1'b0;
    end else begin
      unique case (ev)
        EV_CLEAR: begin
          hit_q   <= 1'b0;
          gcall_q <= 1'b0;
        end
        EV_ADDR: begin
          hit_q   <= verdict.hit;
          gcall_q <= gcall_q | verdict.gcall;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/am_irq.sv
module am_irq
  import slv_addr_match_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  event_e   ev,
  input  verdict_t verdict,
  output logic     irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else begin
      unique case (ev)
        EV_FREE: irq_q <= 1'b1;
        EV_ADDR: irq_q <= verdict.hit;
        default: irq_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import slv_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_first,
  input  logic              fmt_ten,
  input  logic              free_data,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic [BYTE_W-1:0] own_addr,
  output logic              addr_hit,
  output logic              gcall_hit,
  output logic              irq_pulse
);
  verdict_t verdict;
  event_e   ev;
  logic     take;

  assign byte_ready = rst_n;
  assign take       = byte_valid & byte_ready;

  always_comb begin
    if (start_seen | stop_seen)      ev = EV_CLEAR;
    else if (take & free_data)       ev = EV_FREE;
    else if (take & byte_first)      ev = EV_ADDR;
    else                             ev = EV_NONE;
  end

  am_compare #(.W(BYTE_W)) u_cmp (
    .rx_byte (byte_data),
    .own     (own_addr),
    .ten_bit (fmt_ten),
    .verdict (verdict)
  );

  am_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .verdict (verdict),
    .hit_q   (addr_hit),
    .gcall_q (gcall_hit)
  );

  am_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .verdict (verdict),
    .irq_q   (irq_pulse)
  );
endmodule

// File: rtl/slv_addr_match_chk.sv
module slv_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       byte_first,
  input logic       fmt_ten,
  input logic       free_data,
  input logic       start_seen,
  input logic       stop_seen,
  input logic [7:0] own_addr,
  input logic       addr_hit,
  input logic       gcall_hit,
  input logic       irq_pulse
);
  logic quiet;
  assign quiet = !start_seen && !stop_seen;

  // R5
  clear_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen || stop_seen) |=> (!addr_hit && !gcall_hit && !irq_pulse));

  // R6
  hold_non_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !(byte_valid && byte_first)) |=> ($stable(addr_hit) && $stable(gcall_hit)));

  // R8
  free_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_valid && free_data) |=> (irq_pulse && $stable(addr_hit) && $stable(gcall_hit)));

  // R3
  gcall_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_valid && byte_first && !free_data && !fmt_ten && byte_data == 8'h00)
      |=> (addr_hit && gcall_hit));

  // R2
  match_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_valid && byte_first && !free_data && !fmt_ten
      && byte_data[7:1] == own_addr[7:1]) |=> (addr_hit && irq_pulse));

  // R4
  ten_no_gcall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_valid && byte_first && !free_data && fmt_ten && !gcall_hit)
      |=> (!gcall_hit && (addr_hit == $past(byte_data == own_addr))));

  // R9
  irq_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid || !quiet) |=> !irq_pulse);
endmodule

bind slv_addr_match slv_addr_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .byte_first (byte_first),
  .fmt_ten    (fmt_ten),
  .free_data  (free_data),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .own_addr   (own_addr),
  .addr_hit   (addr_hit),
  .gcall_hit  (gcall_hit),
  .irq_pulse  (irq_pulse)
);

// File: tb/slv_addr_match_tb_top.sv
`timescale 1ns/1ps
module slv_addr_match_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [7:0] byte_data = 8'h00;
  logic       byte_first = 1'b0;
  logic       fmt_ten = 1'b0;
  logic       free_data = 1'b0;
  logic       start_seen = 1'b0;
  logic       stop_seen = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic       addr_hit, gcall_hit, irq_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  bit m_hit = 1'b0;
  bit m_gc  = 1'b0;
  bit m_irq = 1'b0;

  always #10 clk = ~clk;

  slv_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_first(byte_first), .fmt_ten(fmt_ten),
    .free_data(free_data), .start_seen(start_seen), .stop_seen(stop_seen),
    .own_addr(own_addr), .addr_hit(addr_hit), .gcall_hit(gcall_hit),
    .irq_pulse(irq_pulse)
  );

  function automatic void model_step(bit v, bit [7:0] d, bit f, bit ten, bit fr,
                                     bit st, bit sp, bit [7:0] own);
    m_irq = 1'b0;
    if (st || sp) begin
      m_hit = 1'b0;
      m_gc  = 1'b0;
    end else if (v) begin
      if (fr) m_irq = 1'b1;
      else if (f) begin
        if (ten) m_hit = (d == own);
        else begin
          m_hit = (d[7:1] == own[7:1]) || (d == 8'h00);
          if (d == 8'h00) m_gc = 1'b1;
        end
        m_irq = m_hit;
      end
    end
  endfunction

  task automatic check(string tag, string what, logic act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit v, bit [7:0] d, bit f, bit ten, bit fr,
                       bit st, bit sp, bit [7:0] own);
    byte_valid = v; byte_data = d; byte_first = f; fmt_ten = ten;
    free_data = fr; start_seen = st; stop_seen = sp; own_addr = own;
    model_step(v, d, f, ten, fr, st, sp, own);
    @(posedge clk);
    @(negedge clk);
    check(tag, "addr_hit", addr_hit, m_hit);
    check(tag, "gcall_hit", gcall_hit, m_gc);
    check(tag, "irq_pulse", irq_pulse, m_irq);
    check(tag, "byte_ready", byte_ready, 1'b1);
  endtask

  initial begin
    #(20ns * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", "addr_hit", addr_hit, 1'b0);
    check("R1", "gcall_hit", gcall_hit, 1'b0);
    check("R1", "irq_pulse", irq_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "byte_ready", byte_ready, 1'b1);

    // R2: direction bit ignored in 7-bit compare
    cycle("R5", 0, 8'h00, 0, 0, 0, 1, 0, 8'hA4);
    cycle("R2", 1, 8'hA5, 1, 0, 0, 0, 0, 8'hA4);
    cycle("R6", 1, 8'h13, 0, 0, 0, 0, 0, 8'hA4);
    cycle("R2", 1, 8'hA6, 1, 0, 0, 0, 0, 8'hA4);
    // R3 and R7: general call is sticky
    cycle("R5", 0, 8'h00, 0, 0, 0, 0, 1, 8'hA4);
    cycle("R3", 1, 8'h00, 1, 0, 0, 0, 0, 8'hA4);
    cycle("R7", 1, 8'h42, 1, 0, 0, 0, 0, 8'hA4);
    cycle("R7", 0, 8'h00, 0, 0, 0, 0, 0, 8'hA4);
    // R5: byte alongside START is dropped
    cycle("R5", 1, 8'hA4, 1, 0, 0, 1, 0, 8'hA4);
    // R4: 10-bit needs all 8 bits; no general call
    cycle("R4", 1, 8'hF1, 1, 1, 0, 0, 0, 8'hF0);
    cycle("R4", 1, 8'hF0, 1, 1, 0, 0, 0, 8'hF0);
    cycle("R4", 1, 8'h00, 1, 1, 0, 0, 0, 8'hF0);
    // R8: free-data mode
    cycle("R2", 1, 8'h30, 1, 0, 0, 0, 0, 8'h31);
    cycle("R8", 1, 8'h00, 1, 0, 1, 0, 0, 8'h31);
    cycle("R8", 1, 8'h77, 0, 0, 1, 0, 0, 8'h31);
    // R9: no irq on non-first byte
    cycle("R9", 1, 8'h30, 0, 0, 0, 0, 0, 8'h31);

    void'($urandom(32'h5eed));
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] own, d;
      bit v, f, ten, fr, st, sp;
      string tag;
      int pick;
      own = (i % 200 == 0) ? 8'($urandom) : own_addr;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1, 2: d = own;
        3, 4:    d = own ^ 8'h01;
        5:       d = 8'h00;
        default: d = 8'($urandom);
      endcase
      v   = ($urandom_range(0, 3) != 0);
      f   = ($urandom_range(0, 1) != 0);
      ten = ($urandom_range(0, 2) == 0);
      fr  = ($urandom_range(0, 7) == 0);
      st  = ($urandom_range(0, 9) == 0);
      sp  = ($urandom_range(0, 14) == 0);
      if (st || sp) tag = "R5";
      else if (v && fr) tag = "R8";
      else if (v && !f) tag = "R6";
      else if (v && ten) tag = "R4";
      else if (v && d == 8'h00) tag = "R3";
      else if (v) tag = "R2";
      else tag = "R7";
      cycle(tag, v, d, f, ten, fr, st, sp, own);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule